// File: doc/BRIEF.md
# Function-Coded Arithmetic Logic Unit with Signed Compare

This block is a registered arithmetic logic unit. It takes two operands and a three-bit operation code and produces a result word, a signed overflow flag and a zero flag. All three outputs are registered and appear one clock after the operands and code are sampled.

The top bit of the code selects whether the second operand goes through as it is or inverted. The same bit is also the carry into the single shared adder, so that one carry chain serves addition, subtraction and the signed compare. The two low bits of the code pick one of four things: the bitwise AND, the bitwise OR, the adder sum, or a compare result. The compare result is the sign of the difference, zero-extended to the full width.

The operand width is a parameter with a default of 32. The checks below use a reduced width to sweep the whole input space.

Top module: `alu_fc`

## Requirements
- R1: While `rst` is high at a rising edge, that edge sets `y_o` to 0, `ovf_o` to 0 and `zero_o` to 1.
- R2: Outside reset, the outputs present after a rising edge depend only on `a_i`, `b_i` and `fn_i` as sampled at that edge.
- R3: Let Bx be `b_i` when `fn_i[2]`=0 and the bitwise inverse of `b_i` when `fn_i[2]`=1. Code bits `fn_i[1:0]`=00 give `a_i` AND Bx, and `fn_i[1:0]`=01 give `a_i` OR Bx.
- R4: Code 010 gives `a_i`+`b_i` and code 110 gives `a_i`-`b_i`, both modulo 2^W. This is the sum `a_i`+Bx+`fn_i[2]`.
- R5: Code 111 gives the most significant bit of `a_i`-`b_i` (modulo 2^W) in bit 0, with every other bit 0. With W=32 or with W=7, A=25 and B=32 give 1.
- R6: For codes 010 and 110, `ovf_o` is the carry into the MSB XOR the carry out of the MSB. This equals the exact signed two's-complement result falling outside the W-bit range.
- R7: For every code whose `fn_i[1:0]` is not 10, `ovf_o` is 0.
- R8: Code 011 gives `y_o`=0.
- R9: `zero_o` is 1 exactly when `y_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| fn_i | input | 3 | Operation code: bit 2 inverts the second operand and sets the carry-in, bits 1:0 select the result |
| y_o | output | W | Registered result |
| ovf_o | output | 1 | Registered signed overflow flag |
| zero_o | output | 1 | Registered flag, high when the result is all zeros |

## Verification
The assertions assume that `a_i`, `b_i` and `fn_i` are known, non-X values at every rising edge outside reset. They compare each output with the inputs sampled one edge earlier, and only after at least one clock edge with reset low. The bench meets these assumptions by driving every input on the falling edge, so the inputs are stable before each rising edge. It holds reset for several cycles before the sweep starts. The sweep covers all eight codes with every operand pair at a width of 7. This includes the sign-boundary pairs, where the compare result and the overflow flag disagree with naive intuition.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_CMP = 2'b11
  } sel_e;

  localparam int FN_W = 3;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  output logic [W-1:0] bx_o,
  output logic         cin_o
);
  always_comb begin
    bx_o  = inv_i ? ~b_i : b_i;
    cin_o = inv_i;
  end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         cout_o
);
  logic [W:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_col
    logic gen_b, prop_b;
    assign gen_b      = a_i[i] & b_i[i];
    assign prop_b     = a_i[i] ^ b_i[i];
    assign sum_o[i]   = prop_b ^ carry[i];
    assign carry[i+1] = gen_b | (prop_b & carry[i]);
  end

  assign c_msb_o = carry[W-1];
  assign cout_o  = carry[W];
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] bx_i,
  input  logic [W-1:0] sum_i,
  input  logic         c_msb_i,
  input  logic         cout_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [W-1:0] y_o,
  output logic         ovf_o
);
  sel_e sel;

  always_comb begin
    sel   = sel_e'(fn_i[1:0]);
    y_o   = '0;
    ovf_o = 1'b0;
    unique case (sel)
      SEL_AND: y_o = a_i & bx_i;
      SEL_OR:  y_o = a_i | bx_i;
      SEL_SUM: begin
        y_o   = sum_i;
        ovf_o = c_msb_i ^ cout_i;
      end
      SEL_CMP: y_o = fn_i[2] ? {{(W-1){1'b0}}, sum_i[W-1]} : '0;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_fc.sv
module alu_fc
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [W-1:0]    y_o,
  output logic            ovf_o,
  output logic            zero_o
);
  logic [W-1:0] bx, sum, y_next;
  logic         cin, c_msb, cout, ovf_next;

  alu_operand_prep #(.W(W)) u_prep (
    .b_i   (b_i),
    .inv_i (fn_i[2]),
    .bx_o  (bx),
    .cin_o (cin)
  );

  alu_ripple_adder #(.W(W)) u_add (
    .a_i     (a_i),
    .b_i     (bx),
    .cin_i   (cin),
    .sum_o   (sum),
    .c_msb_o (c_msb),
    .cout_o  (cout)
  );

  alu_result_mux #(.W(W)) u_mux (
    .a_i     (a_i),
    .bx_i    (bx),
    .sum_i   (sum),
    .c_msb_i (c_msb),
    .cout_i  (cout),
    .fn_i    (fn_i),
    .y_o     (y_next),
    .ovf_o   (ovf_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_o    <= '0;
      ovf_o  <= 1'b0;
      zero_o <= 1'b1;
    end else begin
      y_o    <= y_next;
      ovf_o  <= ovf_next;
      zero_o <= ~|y_next;
    end
  end
endmodule

// File: rtl/alu_fc_checker.sv
module alu_fc_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   fn_i,
  input logic [W-1:0] y_o,
  input logic         ovf_o,
  input logic         zero_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (y_o == '0 && !ovf_o && zero_o));

  p_and_result_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fn_i) == 3'b000) |-> (y_o == ($past(a_i) & $past(b_i))));

  p_cmp_upper_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fn_i) == 3'b111) |-> (y_o[W-1:1] == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fn_i[1:0]) != 2'b10) |-> !ovf_o);

  p_unused_code_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fn_i) == 3'b011) |-> (y_o == '0));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (zero_o == (y_o == '0)));
endmodule

bind alu_fc alu_fc_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .a_i    (a_i),
  .b_i    (b_i),
  .fn_i   (fn_i),
  .y_o    (y_o),
  .ovf_o  (ovf_o),
  .zero_o (zero_o)
);

// File: tb/tb_alu_fc.sv
module tb_alu_fc;
  localparam int W = 7;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic [2:0]   fn = '0;
  logic [W-1:0] y_o;
  logic         ovf_o, zero_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  alu_fc #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .fn_i(fn),
    .y_o(y_o), .ovf_o(ovf_o), .zero_o(zero_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (fn=%0d a=%0d b=%0d)", req, act, exp, fn, a, b);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > (M >> 1)) ? v - (M + 1) : v;
  endfunction

  task automatic expect_of(input int av, input int bv, input int f,
                           output int ey, output int eo);
    int bx, s, r;
    bx = f[2] ? (~bv & M) : bv;
    s  = (av + bx + f[2]) & M;
    eo = 0;
    case (f & 3)
      0: ey = av & bx;
      1: ey = av | bx;
      2: begin
        ey = s;
        r  = f[2] ? sgn(av) - sgn(bv) : sgn(av) + sgn(bv);
        eo = (r > (M >> 1) || r < -((M + 1) >> 1)) ? 1 : 0;
      end
      default: ey = f[2] ? ((s >> (W - 1)) & 1) : 0;
    endcase
  endtask

  function automatic string tag(input int f);
    case (f & 3)
      0, 1: return "R3";
      2:    return "R4";
      default: return f[2] ? "R5" : "R8";
    endcase
  endfunction

  initial begin
    int ey, eo;
    // R1: reset state with live inputs
    a = 7'd5; b = 7'd3; fn = 3'b010;
    repeat (3) @(negedge clk);
    chk("R1 y", y_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 zero", zero_o, 1);

    // R5: known compare 25 < 32
    rst = 1'b0; a = 7'd25; b = 7'd32; fn = 3'b111;
    @(negedge clk);
    chk("R5 25<32", y_o, 1);
    chk("R9 zero", zero_o, 0);

    // full sweep, one vector per cycle (R2 alignment)
    for (int f = 0; f < 8; f++) begin
      for (int av = 0; av <= M; av++) begin
        for (int bv = 0; bv <= M; bv++) begin
          a = av[W-1:0]; b = bv[W-1:0]; fn = f[2:0];
          @(negedge clk);
          expect_of(av, bv, f, ey, eo);
          chk({tag(f), " R2 y"}, y_o, ey);
          chk(((f & 3) == 2) ? "R6 ovf" : "R7 ovf", ovf_o, eo);
          chk("R9 zero", zero_o, (ey == 0) ? 1 : 0);
        end
      end
    end

    // R1 again mid-run
    rst = 1'b1; a = 7'h7f; b = 7'h01; fn = 3'b010;
    @(negedge clk);
    chk("R1 y re", y_o, 0);
    chk("R1 zero re", zero_o, 1);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule